// File: doc/BRIEF.md
# ECC Memory Cycle Controller

This block sequences the control strobes of a dynamic memory array protected by an external error detection and correction unit. A memory cycle engine hands it single-location requests: reads, full-width writes and partial writes. The block turns each into the right series of phases. It drives the array write enable and a disable-byte-marks line that opens every data buffer of the correction unit. It also drives a syndrome-latch strobe, which makes the unit capture its syndrome and flags and generate check bits, a write-zero strobe, and an error strobe for an external error logger.

After reset it runs a fixed warm-up of the array. It then writes zero with valid check bits into every location, using the write-zero strobe. Only then does it accept requests. A partial write becomes an indivisible read-check-write. A corrected value is written back only when the unit reports the error as correctable. When the array has been quiet for a programmable number of cycles, the block reads one location in the background and writes the corrected word back if a correctable error is found. A refresh request from outside gets one dedicated cycle, and the error strobe never fires in that cycle.

Top module: `ecc_cycle_ctrl`

## Requirements
- R1: After reset is released the block spends exactly WARM_CYCLES cycles with `dbm_o` high and `we_o`, `wr_zero_o` low. During that time `busy_o` is high and `init_done_o` and `req_ready` are low.
- R2: Initialisation follows the warm-up. It lasts 2^AW cycles, each with `wr_zero_o`, `we_o` and `dbm_o` high. `mem_addr_o` steps 0, 1, …, 2^AW−1 in that order. Afterwards `init_done_o` is high and `busy_o` is low.
- R3: A read (`req_wr`=0) spends two cycles with `dbm_o` high, and `syn_latch_o` is high in the second. `estb_o` pulses in that second cycle exactly when `err_in` is high and never otherwise. `mem_addr_o` holds the request address for the whole operation.
- R4: When the check cycle of a read or scrub sees `err_in`=1 and `ce_in`=1, one write-back cycle follows with `we_o` and `syn_latch_o` high and `dbm_o` low. For any other combination the operation ends with no write.
- R5: A full write (`req_wr`=1, `req_full`=1) takes one cycle with `we_o` and `syn_latch_o` high and `dbm_o` low.
- R6: A partial write (`req_wr`=1, `req_full`=0) runs the read and check phases of R3 and then one write cycle. The write cycle is skipped only when `err_in`=1 and `ce_in`=0 at the check. `req_ready` stays low for the whole operation.
- R7: A high `rfsh_req` in idle takes priority over a pending request. It causes one cycle with `dbm_o` high and `syn_latch_o`, `estb_o` and `we_o` low, whatever `err_in` is.
- R8: After SCRUB_GAP consecutive idle cycles with neither `req_valid` nor `rfsh_req`, a scrub read and check runs at the scrub pointer, with write-back as in R4. A request that arrives on the cycle the scrub would start is served instead, and the pointer is unchanged.
- R9: The scrub pointer starts at 0, advances by one after each scrub and wraps from 2^AW−1 to 0.
- R10: `req_ready` is high only in idle after initialisation with `rfsh_req` low. A request is taken at a clock edge where `req_valid` and `req_ready` are both high. `busy_o` is high from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Memory request pending |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | 1 = full-width write, 0 = partial write (read-modify-write) |
| req_addr | input | AW | Location of the request |
| req_ready | output | 1 | Request taken at this edge if valid |
| rfsh_req | input | 1 | Refresh cycle wanted |
| err_in | input | 1 | Error detected by the correction unit |
| ce_in | input | 1 | Detected error is correctable |
| we_o | output | 1 | Array write enable |
| dbm_o | output | 1 | Disable byte marks: all data buffers enabled |
| estb_o | output | 1 | Error strobe for an external logger |
| syn_latch_o | output | 1 | Correction unit latches syndrome and flags, generates check bits |
| wr_zero_o | output | 1 | Correction unit forces zero data with check bits |
| mem_addr_o | output | AW | Location of the current cycle |
| busy_o | output | 1 | An operation or the boot sequence is in progress |
| init_done_o | output | 1 | Warm-up and zero initialisation complete |

## Verification
The bound checker tests strobe relations on every cycle. These include write-zero always paired with write and byte marks, the error strobe confined to a check cycle with an error, no write after an uncorrectable check, and no write enable together with byte marks outside initialisation. It also checks that the ready line is masked while busy, before initialisation and under refresh, that initialisation addresses climb by one, and that a taken request starts a cycle at its address. Phase counts, the warm-up length, the exact idle gap before a scrub, the scrub pointer order and wrap, a request pre-empting a scrub, and refresh ordering ahead of a waiting request depend on whole sequences. Only the bench scenarios show those.

// File: rtl/ecc_cyc_pkg.sv
// Shared types for the ECC memory cycle controller.
// Assumes: one state per memory phase; strobes are decoded from the state.
package ecc_cyc_pkg;

    typedef enum logic [3:0] {
        ST_WARM,
        ST_INIT,
        ST_IDLE,
        ST_RFSH,
        ST_RD,
        ST_RD_CHK,
        ST_RD_WB,
        ST_WR,
        ST_PW_RD,
        ST_PW_CHK,
        ST_PW_WR,
        ST_SC_RD,
        ST_SC_CHK,
        ST_SC_WB
    } cyc_state_e;

    typedef struct packed {
        logic we;
        logic dbm;
        logic latch;
        logic wz;
        logic chk;
    } strobe_t;

endpackage

// File: rtl/ecc_boot_seq.sv
// Boot counter: times the warm-up and walks the array addresses during
// zero initialisation. Assumes the FSM raises in_warm / in_init only in
// the matching states, and one counter serves both phases.
module ecc_boot_seq #(
    parameter int AW          = 4,
    parameter int WARM_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_warm,
    input  logic          in_init,
    output logic          warm_last,
    output logic          init_last,
    output logic [AW-1:0] init_addr
);
    localparam int DEPTH = 1 << AW;
    localparam int WBITS = (WARM_CYCLES > 1) ? $clog2(WARM_CYCLES) : 1;
    localparam int CW    = ((WBITS > AW) ? WBITS : AW) + 1;

    logic [CW-1:0] cnt_q;

    // Last-cycle flags for each boot phase.
    always_comb begin
        warm_last = in_warm && (cnt_q == CW'(WARM_CYCLES - 1));
        init_last = in_init && (cnt_q == CW'(DEPTH - 1));
        init_addr = cnt_q[AW-1:0];
    end

    // Shared phase counter, cleared at the end of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (warm_last || init_last) begin
            cnt_q <= '0;
        end else if (in_warm || in_init) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ecc_scrub_track.sv
// Scrub tracker: counts quiet idle cycles and keeps the next scrub location.
// Assumes SCRUB_GAP >= 1 and that scrub_done pulses once per scrub.
module ecc_scrub_track #(
    parameter int AW        = 4,
    parameter int SCRUB_GAP = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          quiet_idle,
    input  logic          scrub_done,
    output logic          scrub_go,
    output logic [AW-1:0] scrub_ptr
);
    localparam int GW = $clog2(SCRUB_GAP + 1);

    logic [GW-1:0] gap_q;
    logic [AW-1:0] ptr_q;

    // A scrub is due on the last cycle of a quiet stretch.
    always_comb begin
        scrub_go  = quiet_idle && (gap_q == GW'(SCRUB_GAP - 1));
        scrub_ptr = ptr_q;
    end

    // Quiet-cycle counter, restarted by any activity or by a launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (!quiet_idle || scrub_go) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Scrub pointer, stepping by one and wrapping at the array top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (scrub_done) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/ecc_cyc_fsm.sv
// Cycle sequencer: chooses between refresh, requests and scrubs, and walks
// each operation through its phases. Assumes err_in/ce_in are valid in the
// check phase and that refresh outranks requests, which outrank scrubs.
module ecc_cyc_fsm
    import ecc_cyc_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rfsh_req,
    input  logic          req_valid,
    input  logic          req_wr,
    input  logic          req_full,
    input  logic [AW-1:0] req_addr,
    input  logic          err_in,
    input  logic          ce_in,
    input  logic          warm_last,
    input  logic          init_last,
    input  logic          scrub_go,
    input  logic [AW-1:0] scrub_ptr,
    output cyc_state_e    state_o,
    output logic [AW-1:0] addr_o,
    output logic          req_ready,
    output logic          quiet_idle
);
    cyc_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          accept;
    logic          fixable;
    logic          fatal;

    // Idle arbitration terms and error classification.
    always_comb begin
        req_ready  = (state_q == ST_IDLE) && !rfsh_req;
        accept     = req_ready && req_valid;
        quiet_idle = (state_q == ST_IDLE) && !rfsh_req && !req_valid;
        fixable    = err_in && ce_in;
        fatal      = err_in && !ce_in;
    end

    // Next-state selection for every phase.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WARM:   if (warm_last) state_d = ST_INIT;
            ST_INIT:   if (init_last) state_d = ST_IDLE;
            ST_IDLE: begin
                if (rfsh_req)             state_d = ST_RFSH;
                else if (accept)          state_d = !req_wr ? ST_RD :
                                                    (req_full ? ST_WR : ST_PW_RD);
                else if (scrub_go)        state_d = ST_SC_RD;
            end
            ST_RFSH:   state_d = ST_IDLE;
            ST_RD:     state_d = ST_RD_CHK;
            ST_RD_CHK: state_d = fixable ? ST_RD_WB : ST_IDLE;
            ST_RD_WB:  state_d = ST_IDLE;
            ST_WR:     state_d = ST_IDLE;
            ST_PW_RD:  state_d = ST_PW_CHK;
            ST_PW_CHK: state_d = fatal ? ST_IDLE : ST_PW_WR;
            ST_PW_WR:  state_d = ST_IDLE;
            ST_SC_RD:  state_d = ST_SC_CHK;
            ST_SC_CHK: state_d = fixable ? ST_SC_WB : ST_IDLE;
            ST_SC_WB:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WARM;
        else        state_q <= state_d;
    end

    // Operation address: captured from the request or the scrub pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
        end else if (state_q == ST_IDLE && !rfsh_req && scrub_go) begin
            addr_q <= scrub_ptr;
        end
    end

    assign state_o = state_q;
    assign addr_o  = addr_q;
endmodule

// File: rtl/ecc_strobe_dec.sv
// Strobe decoder: maps the phase to the array and correction-unit strobes.
// Assumes a purely combinational decode; only the error strobe looks at an input.
module ecc_strobe_dec
    import ecc_cyc_pkg::*;
(
    input  cyc_state_e state,
    input  logic       err_in,
    output strobe_t    stb,
    output logic       estb
);
    // Per-phase strobe table.
    always_comb begin
        stb = '0;
        unique case (state)
            ST_WARM:   stb.dbm = 1'b1;
            ST_INIT:   begin stb.dbm = 1'b1; stb.we = 1'b1; stb.wz = 1'b1; end
            ST_IDLE:   stb = '0;
            ST_RFSH:   stb.dbm = 1'b1;
            ST_RD,
            ST_PW_RD,
            ST_SC_RD:  stb.dbm = 1'b1;
            ST_RD_CHK,
            ST_PW_CHK,
            ST_SC_CHK: begin stb.dbm = 1'b1; stb.latch = 1'b1; stb.chk = 1'b1; end
            ST_RD_WB,
            ST_WR,
            ST_PW_WR,
            ST_SC_WB:  begin stb.we = 1'b1; stb.latch = 1'b1; end
            default:   stb = '0;
        endcase
    end

    // The error strobe fires only in a check phase that saw an error.
    assign estb = stb.chk && err_in;
endmodule

// File: rtl/ecc_cycle_ctrl.sv
// ECC memory cycle controller top: boot sequence, arbitration, operation
// phases and scrubbing. Assumes a single array of 2^AW locations and an
// external correction unit that answers within the check phase.
module ecc_cycle_ctrl
    import ecc_cyc_pkg::*;
#(
    parameter int AW          = 4,
    parameter int WARM_CYCLES = 8,
    parameter int SCRUB_GAP   = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_wr,
    input  logic          req_full,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    input  logic          rfsh_req,
    input  logic          err_in,
    input  logic          ce_in,
    output logic          we_o,
    output logic          dbm_o,
    output logic          estb_o,
    output logic          syn_latch_o,
    output logic          wr_zero_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          busy_o,
    output logic          init_done_o
);
    cyc_state_e    state;
    strobe_t       stb;
    logic [AW-1:0] op_addr;
    logic [AW-1:0] init_addr;
    logic [AW-1:0] scrub_ptr;
    logic          warm_last, init_last, scrub_go, quiet_idle, estb;

    ecc_boot_seq #(.AW(AW), .WARM_CYCLES(WARM_CYCLES)) boot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_warm   (state == ST_WARM),
        .in_init   (state == ST_INIT),
        .warm_last (warm_last),
        .init_last (init_last),
        .init_addr (init_addr)
    );

    ecc_scrub_track #(.AW(AW), .SCRUB_GAP(SCRUB_GAP)) scrub_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .quiet_idle (quiet_idle),
        .scrub_done (state == ST_SC_CHK),
        .scrub_go   (scrub_go),
        .scrub_ptr  (scrub_ptr)
    );

    ecc_cyc_fsm #(.AW(AW)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rfsh_req   (rfsh_req),
        .req_valid  (req_valid),
        .req_wr     (req_wr),
        .req_full   (req_full),
        .req_addr   (req_addr),
        .err_in     (err_in),
        .ce_in      (ce_in),
        .warm_last  (warm_last),
        .init_last  (init_last),
        .scrub_go   (scrub_go),
        .scrub_ptr  (scrub_ptr),
        .state_o    (state),
        .addr_o     (op_addr),
        .req_ready  (req_ready),
        .quiet_idle (quiet_idle)
    );

    ecc_strobe_dec dec_i (
        .state  (state),
        .err_in (err_in),
        .stb    (stb),
        .estb   (estb)
    );

    // Output drive: strobes, address mux and phase status.
    always_comb begin
        we_o        = stb.we;
        dbm_o       = stb.dbm;
        syn_latch_o = stb.latch;
        wr_zero_o   = stb.wz;
        estb_o      = estb;
        mem_addr_o  = (state == ST_INIT) ? init_addr : op_addr;
        busy_o      = (state != ST_IDLE);
        init_done_o = (state != ST_WARM) && (state != ST_INIT);
    end
endmodule

// File: rtl/ecc_cycle_ctrl_chk.sv
// Checker for the ECC memory cycle controller; attached by bind below.
// Observes only the top-level ports.
module ecc_cycle_ctrl_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          req_ready,
    input logic          rfsh_req,
    input logic          err_in,
    input logic          ce_in,
    input logic          we_o,
    input logic          dbm_o,
    input logic          estb_o,
    input logic          syn_latch_o,
    input logic          wr_zero_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          busy_o,
    input logic          init_done_o
);
    assert_no_early_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done_o |-> !req_ready);

    assert_zero_write_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_zero_o |-> (we_o && dbm_o));

    assert_init_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_zero_o && $past(wr_zero_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));

    assert_estb_in_check_R3: assert property (@(posedge clk) disable iff (!rst_n)
        estb_o |-> (syn_latch_o && dbm_o && err_in));

    assert_no_write_uncorrectable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(syn_latch_o && dbm_o && err_in && !ce_in) |-> !we_o);

    assert_write_without_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && !wr_zero_o) |-> !dbm_o);

    assert_refresh_blocks_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_req |-> !req_ready);

    assert_busy_blocks_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !req_ready);

    assert_accept_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy_o && mem_addr_o == $past(req_addr)));
endmodule

bind ecc_cycle_ctrl ecc_cycle_ctrl_chk #(.AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_ready   (req_ready),
    .rfsh_req    (rfsh_req),
    .err_in      (err_in),
    .ce_in       (ce_in),
    .we_o        (we_o),
    .dbm_o       (dbm_o),
    .estb_o      (estb_o),
    .syn_latch_o (syn_latch_o),
    .wr_zero_o   (wr_zero_o),
    .mem_addr_o  (mem_addr_o),
    .busy_o      (busy_o),
    .init_done_o (init_done_o)
);

// File: tb/ecc_cycle_ctrl_tb.sv
// Self-checking bench: boot, scrub sweep, full request sweep, pre-emption, refresh.
module ecc_cycle_ctrl_tb_top;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int WARM  = 8;
    localparam int GAP   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_wr = 1'b0, req_full = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          rfsh_req = 1'b0, err_in = 1'b0, ce_in = 1'b0;
    logic          req_ready, we_o, dbm_o, estb_o, syn_latch_o, wr_zero_o, busy_o, init_done_o;
    logic [AW-1:0] mem_addr_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    int t_len, t_dbm, t_we, t_estb, t_latch, t_addr_bad, t_rdy_bad;
    int t_addr;

    always #10 clk = ~clk;

    ecc_cycle_ctrl #(.AW(AW), .WARM_CYCLES(WARM), .SCRUB_GAP(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
        .req_full(req_full), .req_addr(req_addr), .req_ready(req_ready),
        .rfsh_req(rfsh_req), .err_in(err_in), .ce_in(ce_in), .we_o(we_o),
        .dbm_o(dbm_o), .estb_o(estb_o), .syn_latch_o(syn_latch_o),
        .wr_zero_o(wr_zero_o), .mem_addr_o(mem_addr_o), .busy_o(busy_o),
        .init_done_o(init_done_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic next_sample();
        @(negedge clk);
        #1;
    endtask

    // Follows one busy stretch from the current sample to the first idle one.
    task automatic run_trace();
        t_len = 0; t_dbm = 0; t_we = 0; t_estb = 0; t_latch = 0;
        t_addr_bad = 0; t_rdy_bad = 0;
        t_addr = int'(mem_addr_o);
        while (busy_o) begin
            t_len++;
            t_dbm   += int'(dbm_o);
            t_we    += int'(we_o);
            t_estb  += int'(estb_o);
            t_latch += int'(syn_latch_o);
            if (int'(mem_addr_o) != t_addr) t_addr_bad++;
            if (req_ready) t_rdy_bad++;
            next_sample();
        end
    endtask

    // Issues one request from an idle sample and traces it.
    task automatic do_req(input bit wr, input bit full, input int adr,
                          input bit e, input bit c, input string tag);
        req_valid = 1'b1; req_wr = wr; req_full = full;
        req_addr = AW'(adr); err_in = e; ce_in = c;
        #1;
        check(req_ready == 1'b1, {tag, " R10 ready in idle"}, int'(req_ready), 1);
        next_sample();
        req_valid = 1'b0;
        run_trace();
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d expected %0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int warm_n, init_n, init_bad, idle_n;
        bit e, c, wb_exp, pw_wr;
        int adr;

        // Reset state (R1, R10)
        repeat (3) next_sample();
        check(busy_o == 1'b1 && req_ready == 1'b0 && init_done_o == 1'b0 && we_o == 1'b0,
              "R1 reset state", int'({busy_o, req_ready, init_done_o, we_o}), 8);

        // Warm-up (R1)
        rst_n = 1'b1;
        #1;
        warm_n = 0; init_bad = 0;
        while (dbm_o && !wr_zero_o && warm_n < 100) begin
            if (we_o || req_ready || init_done_o) init_bad++;
            warm_n++;
            next_sample();
        end
        check(warm_n == WARM, "R1 warm-up length", warm_n, WARM);
        check(init_bad == 0, "R1 warm-up strobes quiet", init_bad, 0);

        // Zero initialisation (R2)
        init_n = 0; init_bad = 0;
        while (wr_zero_o && init_n < 100) begin
            if (!we_o || !dbm_o || int'(mem_addr_o) != init_n) init_bad++;
            init_n++;
            next_sample();
        end
        check(init_n == DEPTH, "R2 init length", init_n, DEPTH);
        check(init_bad == 0, "R2 init strobes and address order", init_bad, 0);
        check(init_done_o && !busy_o, "R2 init done", int'({init_done_o, busy_o}), 2);

        // Scrub sweep with pointer wrap (R8, R9, R4)
        for (int i = 0; i <= DEPTH; i++) begin
            e = (i % 3 == 0);
            c = (i % 2 == 0);
            err_in = e; ce_in = c;
            idle_n = 0;
            while (!busy_o && idle_n < 1000) begin
                idle_n++;
                next_sample();
            end
            check(idle_n == GAP, $sformatf("R8 quiet gap before scrub %0d", i), idle_n, GAP);
            run_trace();
            wb_exp = e && c;
            check(t_addr == (i % DEPTH), $sformatf("R9 scrub %0d pointer", i), t_addr, i % DEPTH);
            check(t_len == 2 + int'(wb_exp), $sformatf("R8 scrub %0d length", i), t_len, 2 + int'(wb_exp));
            check(t_we == int'(wb_exp), $sformatf("R4 scrub %0d write-back", i), t_we, int'(wb_exp));
            check(t_estb == int'(e), $sformatf("R3 scrub %0d error strobe", i), t_estb, int'(e));
        end
        err_in = 1'b0; ce_in = 1'b0;

        // Request sweep: read, full write, partial write x error combinations
        for (int k = 0; k < 3; k++) begin
            for (int ec = 0; ec < 4; ec++) begin
                e = ec[1];
                c = ec[0];
                adr = (k * 5 + ec * 3 + 1) % DEPTH;
                if (k == 0) begin
                    do_req(1'b0, 1'b0, adr, e, c, "read");
                    wb_exp = e && c;
                    check(t_len == 2 + int'(wb_exp), "R3 read length", t_len, 2 + int'(wb_exp));
                    check(t_dbm == 2, "R3 read byte marks", t_dbm, 2);
                    check(t_latch == 1 + int'(wb_exp), "R3 read latch count", t_latch, 1 + int'(wb_exp));
                    check(t_estb == int'(e), "R3 read error strobe", t_estb, int'(e));
                    check(t_we == int'(wb_exp), "R4 read write-back", t_we, int'(wb_exp));
                end else if (k == 1) begin
                    do_req(1'b1, 1'b1, adr, e, c, "full");
                    check(t_len == 1 && t_we == 1 && t_latch == 1 && t_dbm == 0 && t_estb == 0,
                          "R5 full write phases", t_len * 10 + t_dbm, 10);
                end else begin
                    do_req(1'b1, 1'b0, adr, e, c, "partial");
                    pw_wr = !(e && !c);
                    check(t_len == 2 + int'(pw_wr), "R6 partial length", t_len, 2 + int'(pw_wr));
                    check(t_we == int'(pw_wr), "R6 partial write", t_we, int'(pw_wr));
                    check(t_dbm == 2 && t_estb == int'(e), "R6 partial read phase",
                          t_dbm * 10 + t_estb, 20 + int'(e));
                    check(t_rdy_bad == 0, "R6 ready low while busy", t_rdy_bad, 0);
                end
                check(t_addr == adr && t_addr_bad == 0, "R3 address held",
                      t_addr, adr);
            end
        end
        err_in = 1'b0; ce_in = 1'b0;

        // Request on the launch cycle pre-empts the scrub (R8, R9)
        repeat (GAP - 1) next_sample();
        do_req(1'b1, 1'b1, 9, 1'b0, 1'b0, "preempt");
        check(t_addr == 9 && t_len == 1, "R8 request wins over scrub", t_addr, 9);
        idle_n = 0;
        while (!busy_o && idle_n < 1000) begin
            idle_n++;
            next_sample();
        end
        check(idle_n == GAP, "R8 gap after pre-emption", idle_n, GAP);
        run_trace();
        check(t_addr == (DEPTH + 1) % DEPTH, "R9 pointer unchanged by pre-emption",
              t_addr, (DEPTH + 1) % DEPTH);

        // Refresh outranks a pending read and never strobes errors (R7)
        rfsh_req = 1'b1; req_valid = 1'b1; req_wr = 1'b0; req_addr = AW'(5);
        err_in = 1'b1; ce_in = 1'b1;
        #1;
        check(req_ready == 1'b0, "R7 ready masked by refresh", int'(req_ready), 0);
        next_sample();
        check(busy_o && dbm_o && !syn_latch_o && !estb_o && !we_o, "R7 refresh cycle strobes",
              int'({busy_o, dbm_o, syn_latch_o, estb_o, we_o}), 24);
        rfsh_req = 1'b0;
        #1;
        next_sample();
        check(!busy_o && req_ready, "R10 idle after refresh", int'({busy_o, req_ready}), 1);
        next_sample();
        req_valid = 1'b0;
        run_trace();
        check(t_addr == 5 && t_len == 3 && t_we == 1, "R7 waiting read served after refresh",
              t_addr * 10 + t_len, 53);
        err_in = 1'b0; ce_in = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule